// File: doc/BRIEF.md
# If-Then Conditional Execution Tracker

This block sits beside a processor's decode stage and predicates the short run of instructions that follows an If-Then instruction. When decode accepts an If-Then instruction, the block captures the base condition and a pattern of up to four slots. The first slot is always a Then slot. Each later slot is either Then, which uses the base condition, or Else, which uses its inverse. For each instruction that then reaches decode, the block tests the current slot's condition against the N, Z, C and V flags and reports whether the instruction executes. It also reports whether a 16-bit instruction may write the flags.

The whole tracking state fits in one 8-bit value, which is always visible on an output. It can be saved when an interrupt arrives and written back in one cycle on exception return, so an interrupted block resumes at the slot where it stopped. A taken branch that leaves the block before its last slot abandons the block and raises an error strobe.

Top module: `it_tracker`

## Requirements
- R1: While reset is held low, and after it is released, `state_o` is 0 and `in_block_o` is 0.
- R2: Outside a block, `exec_o` and `flag_wr_ok_o` are 1. A retire outside a block leaves `state_o` at 0.
- R3: Condition codes are evaluated on flags given as {N,Z,C,V}. The codes are: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always, 15 always.
- R4: On `it_load_i` with a nonzero mask, the block length is set by the lowest set bit of the mask: bit 3 gives 1 slot and bit 0 gives 4 slots. Mask bits 3, 2 and 1 above that bit give slots 2, 3 and 4, where 1 means Else. The state becomes {cond[3:1], cond[0], s[3:0]}, with s = mask XOR (cond[0] on each bit above the lowest set bit).
- R5: An `it_load_i` with mask 0 is ignored.
- R6: Each retire inside a block moves to the next slot one cycle later. Bits [7:5] are kept and bits [4:0] shift left by one. After the last slot retires, the state becomes 0. An Else slot executes when the base condition fails.
- R7: Inside a block, `flag_wr_ok_o` is 0 for a 16-bit instruction that is not a comparison, and 1 for a comparison or a 32-bit instruction.
- R8: `restore_i` loads `restore_state_i` into the state on the next edge and takes priority over `it_load_i`. The block then continues from the restored slot.
- R9: A taken branch retiring inside a block before its last slot raises `branch_err_o` in that cycle and clears the state. A taken branch in the last slot, or outside a block, raises no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nzcv_i | input | 4 | Condition flags {N,Z,C,V} |
| it_load_i | input | 1 | Decoded If-Then instruction accepted |
| it_cond_i | input | 4 | Base condition of the If-Then instruction |
| it_mask_i | input | 4 | Slot pattern of the If-Then instruction |
| retire_i | input | 1 | Instruction in decode retires |
| wide_i | input | 1 | That instruction is 32-bit |
| cmp_i | input | 1 | That instruction is a comparison |
| branch_i | input | 1 | That instruction is a taken branch |
| restore_i | input | 1 | Reload saved state (exception return) |
| restore_state_i | input | 8 | Saved state value |
| in_block_o | output | 1 | A block is active |
| exec_o | output | 1 | Current instruction executes |
| flag_wr_ok_o | output | 1 | Current instruction may write flags |
| branch_err_o | output | 1 | Illegal branch out of an active block |
| state_o | output | 8 | Current tracking state |

## Verification
A table walks every condition code through a one-slot block, with flag values chosen so that each code gives the answer that sets it apart from its inverse. Two extra rows check that HI and GT depend on the combination of flags. Multi-slot blocks with alternating Then/Else patterns, one on each base-condition polarity, show that Else slots invert the test and that the block ends after exactly the encoded length. A save, overwrite and restore sequence shows that execution resumes at the saved slot and that restore outranks a new load. Branches in a middle slot, in the last slot and outside any block separate the error case from the two legal ones.

// File: rtl/it_tracker.sv
module it_tracker (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] nzcv_i,
  input  logic       it_load_i,
  input  logic [3:0] it_cond_i,
  input  logic [3:0] it_mask_i,
  input  logic       retire_i,
  input  logic       wide_i,
  input  logic       cmp_i,
  input  logic       branch_i,
  input  logic       restore_i,
  input  logic [7:0] restore_state_i,
  output logic       in_block_o,
  output logic       exec_o,
  output logic       flag_wr_ok_o,
  output logic       branch_err_o,
  output logic [7:0] state_o
);

  logic [7:0] st_q;
  logic [3:0] cur_cond;
  logic       active, last_slot, pass;
  logic [3:0] above, slot_bits;
  logic       fn, fz, fc, fv;

  assign {fn, fz, fc, fv} = nzcv_i;
  assign active    = st_q[3:0] != 4'b0;
  assign last_slot = st_q[2:0] == 3'b0;
  assign cur_cond  = {st_q[7:5], st_q[4]};

  always_comb begin
    case (cur_cond)
      4'd0:    pass = fz;
      4'd1:    pass = !fz;
      4'd2:    pass = fc;
      4'd3:    pass = !fc;
      4'd4:    pass = fn;
      4'd5:    pass = !fn;
      4'd6:    pass = fv;
      4'd7:    pass = !fv;
      4'd8:    pass = fc && !fz;
      4'd9:    pass = !fc || fz;
      4'd10:   pass = fn == fv;
      4'd11:   pass = fn != fv;
      4'd12:   pass = !fz && (fn == fv);
      4'd13:   pass = fz || (fn != fv);
      default: pass = 1'b1;
    endcase
  end

  // bits above the terminating one carry polarity relative to cond[0]
  assign above     = {|it_mask_i[2:0], |it_mask_i[1:0], it_mask_i[0], 1'b0};
  assign slot_bits = it_mask_i ^ ({4{it_cond_i[0]}} & above);

  always_ff @(posedge clk) begin
    if (!rst_n)
      st_q <= 8'h00;
    else if (restore_i)
      st_q <= restore_state_i;
    else if (it_load_i && it_mask_i != 4'b0)
      st_q <= {it_cond_i, slot_bits};
    else if (retire_i && active) begin
      if (last_slot || branch_i)
        st_q <= 8'h00;
      else
        st_q <= {st_q[7:5], st_q[3:0], 1'b0};
    end
  end

  assign state_o      = st_q;
  assign in_block_o   = active;
  assign exec_o       = !active || pass;
  assign flag_wr_ok_o = !active || wide_i || cmp_i;
  assign branch_err_o = retire_i && branch_i && active && !last_slot;

  p_reset_r1: assert property (@(posedge clk) !rst_n |=> state_o == 8'h00);

  p_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_block_o |-> exec_o && flag_wr_ok_o);

  p_empty_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !restore_i && it_load_i && it_mask_i == 4'b0 && !in_block_o |=> !in_block_o);

  p_advance_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_block_o && retire_i && !branch_i && !restore_i && !it_load_i && state_o[2:0] != 3'b0
    |=> state_o == {$past(state_o[7:5]), $past(state_o[3:0]), 1'b0});

  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_block_o && retire_i && !restore_i && !it_load_i && state_o[2:0] == 3'b0
    |=> state_o == 8'h00);

  p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    restore_i |=> state_o == $past(restore_state_i));

  p_brerr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    branch_err_o && !restore_i && !it_load_i |=> !in_block_o);

endmodule

// File: tb/test_it_tracker.sv
module test_it_tracker;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nzcv_i = '0;
  logic       it_load_i = 1'b0;
  logic [3:0] it_cond_i = '0;
  logic [3:0] it_mask_i = '0;
  logic       retire_i = 1'b0, wide_i = 1'b0, cmp_i = 1'b0, branch_i = 1'b0;
  logic       restore_i = 1'b0;
  logic [7:0] restore_state_i = '0;
  logic       in_block_o, exec_o, flag_wr_ok_o, branch_err_o;
  logic [7:0] state_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] saved;

  // {cond, nzcv, expected exec}
  localparam logic [8:0] TBL [18] = '{
    {4'd0,  4'b0100, 1'b1}, {4'd1,  4'b0100, 1'b0}, {4'd2,  4'b0010, 1'b1},
    {4'd3,  4'b0010, 1'b0}, {4'd4,  4'b1000, 1'b1}, {4'd5,  4'b1000, 1'b0},
    {4'd6,  4'b0000, 1'b0}, {4'd7,  4'b0000, 1'b1}, {4'd8,  4'b0010, 1'b1},
    {4'd9,  4'b0110, 1'b1}, {4'd10, 4'b1001, 1'b1}, {4'd11, 4'b1000, 1'b1},
    {4'd12, 4'b0100, 1'b0}, {4'd13, 4'b0001, 1'b1}, {4'd14, 4'b0000, 1'b1},
    {4'd15, 4'b0000, 1'b1}, {4'd8,  4'b0110, 1'b0}, {4'd12, 4'b1001, 1'b1}
  };

  it_tracker i_it_tracker (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic load_it(input logic [3:0] c, input logic [3:0] m);
    @(negedge clk);
    it_load_i = 1; it_cond_i = c; it_mask_i = m;
    @(negedge clk);
    it_load_i = 0;
    #1;
  endtask

  task automatic retire(input logic br);
    @(negedge clk);
    retire_i = 1; branch_i = br;
    #1;
  endtask

  task automatic step();
    @(negedge clk);
    retire_i = 0; branch_i = 0; restore_i = 0; it_load_i = 0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 state", state_o, 8'h00);
    check("R1 in_block", {7'b0, in_block_o}, 8'h00);
    rst_n = 1;
    @(negedge clk); #1;
    check("R1 state after release", state_o, 8'h00);
    check("R2 exec outside", {7'b0, exec_o}, 8'h01);
    check("R2 flag write outside", {7'b0, flag_wr_ok_o}, 8'h01);
    retire(0); step();
    check("R2 retire outside", state_o, 8'h00);

    // R3 table walk
    for (int k = 0; k < 18; k++) begin
      load_it(TBL[k][8:5], 4'b1000);
      nzcv_i = TBL[k][4:1];
      #1;
      check("R3 exec", {7'b0, exec_o}, {7'b0, TBL[k][0]});
      retire(0); step();
      check("R6 one-slot end", {7'b0, in_block_o}, 8'h00);
    end

    // R4/R6 EQ, T E T E
    nzcv_i = 4'b0100;
    load_it(4'd0, 4'b1011);
    check("R4 state encode", state_o, 8'h0B);
    check("R6 slot1 then", {7'b0, exec_o}, 8'h01);
    retire(0); step();
    check("R6 state shift", state_o, 8'h16);
    check("R6 slot2 else", {7'b0, exec_o}, 8'h00);
    retire(0); step();
    check("R6 slot3 then", {7'b0, exec_o}, 8'h01);
    retire(0); step();
    check("R6 slot4 else", {7'b0, exec_o}, 8'h00);
    check("R6 still in block", {7'b0, in_block_o}, 8'h01);
    retire(0); step();
    check("R6 end after four", state_o, 8'h00);

    // R4 NE, T E
    nzcv_i = 4'b0000;
    load_it(4'd1, 4'b1100);
    check("R4 state encode NE", state_o, 8'h14);
    check("R6 NE slot1", {7'b0, exec_o}, 8'h01);
    retire(0); step();
    check("R6 NE slot2 else", {7'b0, exec_o}, 8'h00);
    retire(0); step();
    check("R6 end after two", {7'b0, in_block_o}, 8'h00);

    // R5
    load_it(4'd0, 4'b0000);
    check("R5 empty mask ignored", state_o, 8'h00);
    check("R5 exec", {7'b0, exec_o}, 8'h01);

    // R7
    load_it(4'd14, 4'b1000);
    #1;
    check("R7 narrow no cmp", {7'b0, flag_wr_ok_o}, 8'h00);
    cmp_i = 1; #1;
    check("R7 narrow cmp", {7'b0, flag_wr_ok_o}, 8'h01);
    cmp_i = 0; wide_i = 1; #1;
    check("R7 wide", {7'b0, flag_wr_ok_o}, 8'h01);
    wide_i = 0;
    retire(0); step();

    // R8 save / overwrite / restore
    nzcv_i = 4'b0100;
    load_it(4'd0, 4'b1011);
    retire(0); step();
    saved = state_o;
    load_it(4'd4, 4'b1000);
    check("R8 overwritten", state_o, 8'h48);
    @(negedge clk);
    restore_i = 1; restore_state_i = saved;
    it_load_i = 1; it_cond_i = 4'd14; it_mask_i = 4'b1000;
    step();
    check("R8 restored over load", state_o, 8'h16);
    check("R8 resumed slot2", {7'b0, exec_o}, 8'h00);
    retire(0); step();
    check("R8 resumed slot3", state_o, 8'h0C);
    retire(0); step();
    retire(0); step();
    check("R8 end after resume", state_o, 8'h00);

    // R9
    load_it(4'd14, 4'b1010);
    retire(1);
    check("R9 mid branch error", {7'b0, branch_err_o}, 8'h01);
    step();
    check("R9 block abandoned", {7'b0, in_block_o}, 8'h00);
    load_it(4'd14, 4'b1000);
    retire(1);
    check("R9 last slot branch ok", {7'b0, branch_err_o}, 8'h00);
    step();
    retire(1);
    check("R9 outside branch ok", {7'b0, branch_err_o}, 8'h00);
    step();

    finish_run();
  end
endmodule